// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital timing controller for a successive-approximation converter. It makes a converter-clock enable from the peripheral clock through an 8-bit prescaler. After a start request it first holds a warm-up dwell. It then opens a sampling window and hands a convert request to the analog core. It stores the result that the core returns. All phase lengths are counted in converter-clock units, and each unit is (prescale + 1) peripheral clock cycles.

In single-shot mode one conversion is made and the sequencer goes back to idle. In continuous mode a new sampling window opens once per programmed repeat interval, until a stop request ends the run. Software loads a configuration word through a write strobe, and the load is accepted only while the sequencer is idle. The channel, reference and scale selects are held steady on outputs for the analog multiplexer. A sticky done flag and a gated interrupt report each stored result.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is held and after its release, busy, done, irq, sample_en and conv_start are 0 and result is 0.
- R2: The converter tick fires once every (prescale + 1) clock cycles while busy, for any prescale value from 0 to 255. After start is sampled, sample_en stays 0 for exactly (prescale + 1) × max(warm, 1) cycles.
- R3: sample_en is high for exactly (prescale + 1) × max(samp, 1) consecutive cycles.
- R4: conv_start is a one-cycle pulse in the first cycle after sample_en falls. The sequencer then waits for res_valid without any time limit.
- R5: When res_valid is high during the conversion phase, res_data goes to result and done is set on the same edge. A res_valid outside that phase changes neither result nor done.
- R6: In single-shot mode (cfg_cont = 0), busy is 0 on the cycle after the result is stored, and no further sampling window opens.
- R7: In continuous mode (cfg_cont = 1), a new sampling window opens (prescale + 1) × rate cycles after the previous one opened. If the conversion is still running when that interval ends, the next window opens on the first tick after the result is stored.
- R8: A stop request during sampling or conversion lets that conversion finish and store its result, and the sequencer then goes idle. A stop during warm-up or during the wait between conversions returns the sequencer to idle on the next edge, with no result stored.
- R9: done stays 1 until done_clr is sampled. If a result is stored on the same edge as a done_clr, done stays 1 and holds the new result.
- R10: irq equals done AND the stored interrupt-enable bit.
- R11: mux_ch follows the configured conversion channel and scale_sel follows the configured scale. With cfg_abs = 1 (absolute), ref_en = 0 and ref_ch = 0. With cfg_abs = 0 (differential), ref_en = 1 and ref_ch carries the configured reference channel.
- R12: A cfg_wr while busy is dropped: the selects and the phase timing of the running sequence do not change, and the dropped values do not appear after the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_prescale | input | 8 | Converter clock divider minus one |
| cfg_warm | input | 8 | Warm-up dwell in converter units |
| cfg_samp | input | 8 | Sampling window in converter units |
| cfg_rate | input | 16 | Continuous repeat interval in converter units |
| cfg_cont | input | 1 | 1 = continuous, 0 = single shot |
| cfg_abs | input | 1 | 1 = absolute, 0 = differential |
| cfg_irq_en | input | 1 | Completion interrupt enable |
| cfg_conv_ch | input | 3 | Conversion channel |
| cfg_ref_ch | input | 3 | Reference channel for differential mode |
| cfg_scale | input | 3 | Input scale code |
| start | input | 1 | Start request, accepted only when idle |
| stop | input | 1 | Stop request |
| done_clr | input | 1 | Clears the done flag |
| sample_en | output | 1 | Analog sample window |
| conv_start | output | 1 | Convert request pulse to the analog core |
| res_valid | input | 1 | Analog result strobe |
| res_data | input | 12 | Analog result value |
| busy | output | 1 | Sequencer not idle |
| result | output | 12 | Latest stored conversion |
| done | output | 1 | Sticky result-stored flag |
| irq | output | 1 | Completion interrupt |
| mux_ch | output | 3 | Channel select to the multiplexer |
| ref_ch | output | 3 | Reference channel select |
| ref_en | output | 1 | Differential reference in use |
| scale_sel | output | 3 | Input scale select |

## Verification
A result store and a software clear of the done flag can arrive on the same clock edge. The bench makes this happen by switching off its analog model, starting a conversion over, and waiting for conv_start. It then drives res_valid, fresh res_data and done_clr together on a single cycle. The check passes only if, one cycle later, done is still 1 and result holds the fresh value. A separate clear on a later cycle must then bring done to 0.

// File: rtl/adc_seq_pkg.sv
// Shared widths, the sequencer state type and the configuration record.
// Assumes every user of the block imports this package.
package adc_seq_pkg;
    parameter int PRE_W  = 8;
    parameter int WARM_W = 8;
    parameter int SAMP_W = 8;
    parameter int RATE_W = 16;
    parameter int CH_W   = 3;
    parameter int SCL_W  = 3;
    parameter int DATA_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WARM,
        ST_SAMPLE,
        ST_CONVERT,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic [PRE_W-1:0]  prescale;
        logic [WARM_W-1:0] warm;
        logic [SAMP_W-1:0] samp;
        logic [RATE_W-1:0] rate;
        logic              cont;
        logic              absm;
        logic              irq_en;
        logic [CH_W-1:0]   conv_ch;
        logic [CH_W-1:0]   ref_ch;
        logic [SCL_W-1:0]  scale;
    } seq_cfg_t;
endpackage

// File: rtl/adc_seq_cfg.sv
// Configuration holding register. It loads the incoming word on a write
// strobe only while the sequencer reports idle. Assumes cfg_in is stable
// during the strobe cycle.
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  logic     idle,
    input  seq_cfg_t cfg_in,
    output seq_cfg_t cfg_q
);
    // Load the configuration when written in idle; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr && idle)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/adc_seq_tick.sv
// Converter clock enable. It counts peripheral clocks and pulses once every
// (prescale + 1) cycles while run is high. The count is held at zero while
// idle, so the phase starts fresh on each run.
module adc_seq_tick
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    assign tick = run && (cnt == prescale);

    // Advance the divider count and wrap it at the prescale value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + PRE_W'(1);
    end

    // With a nonzero prescale, two ticks never fall on adjacent cycles.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0) |=> !tick);
endmodule

// File: rtl/adc_seq_fsm.sv
// Phase sequencer: warm-up, sample, convert and the wait between repeats.
// Phase lengths are counted in converter ticks. The conversion phase waits
// on the analog strobe with no time limit. Assumes the configuration stays
// stable while busy.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              stop,
    input  logic              done_clr,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [WARM_W-1:0] warm,
    input  logic [SAMP_W-1:0] samp,
    input  logic [RATE_W-1:0] rate,
    input  logic              cont,
    output logic              busy,
    output logic              sample_en,
    output logic              conv_start,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    localparam int CNT_W = (WARM_W > SAMP_W) ? WARM_W : SAMP_W;

    seq_state_t        state, nxt;
    logic [CNT_W-1:0]  ucnt;
    logic [CNT_W:0]    u_inc;
    logic [RATE_W-1:0] rcnt;
    logic [RATE_W:0]   r_inc;
    logic              warm_met, samp_met, rate_met, store, issued, stop_pend;

    assign u_inc    = {1'b0, ucnt} + (CNT_W+1)'(1);
    assign r_inc    = {1'b0, rcnt} + (RATE_W+1)'(1);
    assign warm_met = u_inc >= (CNT_W+1)'(warm);
    assign samp_met = u_inc >= (CNT_W+1)'(samp);
    assign rate_met = r_inc >= (RATE_W+1)'(rate);
    assign store    = (state == ST_CONVERT) && res_valid;

    assign busy       = (state != ST_IDLE);
    assign sample_en  = (state == ST_SAMPLE);
    assign conv_start = (state == ST_CONVERT) && !issued;

    // Choose the next phase from the ticks, the strobes and the stop request.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_WARM;
            ST_WARM:    if (stop) nxt = ST_IDLE;
                        else if (tick && warm_met) nxt = ST_SAMPLE;
            ST_SAMPLE:  if (tick && samp_met) nxt = ST_CONVERT;
            ST_CONVERT: if (store) nxt = (cont && !stop_pend && !stop) ? ST_GAP : ST_IDLE;
            ST_GAP:     if (stop) nxt = ST_IDLE;
                        else if (tick && rate_met) nxt = ST_SAMPLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Register the state, the convert-issued marker and the pending stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            issued    <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            state  <= nxt;
            issued <= (state == ST_CONVERT);
            if (nxt == ST_IDLE)
                stop_pend <= 1'b0;
            else if (stop && busy)
                stop_pend <= 1'b1;
        end
    end

    // Count ticks inside the warm-up and sampling phases.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state)
            ucnt <= '0;
        else if (tick)
            ucnt <= u_inc[CNT_W-1:0];
    end

    // Count ticks since the last sampling window opened, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt <= '0;
        else if (nxt == ST_SAMPLE && state != ST_SAMPLE)
            rcnt <= '0;
        else if (tick && state != ST_IDLE && state != ST_WARM && !(&rcnt))
            rcnt <= r_inc[RATE_W-1:0];
    end

    // Capture the result and keep done set until cleared; a store beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else if (store) begin
            result <= res_data;
            done   <= 1'b1;
        end else if (done_clr) begin
            done   <= 1'b0;
        end
    end

    assert_pulse_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_sample_then_convert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_en) |-> conv_start);
    assert_store_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (done && result == $past(res_data)));
    assert_single_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !cont) |=> !busy);
    assert_stop_in_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && state == ST_GAP) |=> !busy);
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);
endmodule

// File: rtl/adc_seq_top.sv
// Top of the converter timing sequencer. It joins the configuration
// register, the tick divider and the phase machine, and drives the static
// selects and the interrupt. Assumes the analog core answers conv_start
// with a single-cycle res_valid.
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [WARM_W-1:0] cfg_warm,
    input  logic [SAMP_W-1:0] cfg_samp,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_cont,
    input  logic              cfg_abs,
    input  logic              cfg_irq_en,
    input  logic [CH_W-1:0]   cfg_conv_ch,
    input  logic [CH_W-1:0]   cfg_ref_ch,
    input  logic [SCL_W-1:0]  cfg_scale,
    input  logic              start,
    input  logic              stop,
    input  logic              done_clr,
    output logic              sample_en,
    output logic              conv_start,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic              irq,
    output logic [CH_W-1:0]   mux_ch,
    output logic [CH_W-1:0]   ref_ch,
    output logic              ref_en,
    output logic [SCL_W-1:0]  scale_sel
);
    seq_cfg_t cfg_in, cfg_q;
    logic     tick;

    assign cfg_in = '{prescale: cfg_prescale, warm: cfg_warm, samp: cfg_samp,
                      rate: cfg_rate, cont: cfg_cont, absm: cfg_abs,
                      irq_en: cfg_irq_en, conv_ch: cfg_conv_ch,
                      ref_ch: cfg_ref_ch, scale: cfg_scale};

    adc_seq_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idle(!busy),
        .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    adc_seq_tick u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .prescale(cfg_q.prescale), .tick(tick)
    );

    adc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
        .done_clr(done_clr), .res_valid(res_valid), .res_data(res_data),
        .warm(cfg_q.warm), .samp(cfg_q.samp), .rate(cfg_q.rate),
        .cont(cfg_q.cont), .busy(busy), .sample_en(sample_en),
        .conv_start(conv_start), .result(result), .done(done)
    );

    // Static selects for the analog multiplexer and the completion interrupt.
    always_comb begin
        mux_ch    = cfg_q.conv_ch;
        scale_sel = cfg_q.scale;
        ref_en    = !cfg_q.absm;
        ref_ch    = cfg_q.absm ? '0 : cfg_q.ref_ch;
        irq       = done && cfg_q.irq_en;
    end

    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mux_ch) && $stable(ref_en) && $stable(scale_sel)));
    assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done);
endmodule

// File: tb/test_adc_seq_top.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for stop, dropped configuration and the store/clear collision.
module test_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, cfg_cont, cfg_abs, cfg_irq_en;
    logic [7:0]  cfg_prescale, cfg_warm, cfg_samp;
    logic [15:0] cfg_rate;
    logic [2:0]  cfg_conv_ch, cfg_ref_ch, cfg_scale;
    logic        start, stop, done_clr, res_valid;
    logic [11:0] res_data;
    logic        sample_en, conv_start, busy, done, irq, ref_en;
    logic [11:0] result;
    logic [2:0]  mux_ch, ref_ch, scale_sel;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b1;
    logic [11:0] model_data = '0;

    always #10 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale),
        .cfg_warm(cfg_warm), .cfg_samp(cfg_samp), .cfg_rate(cfg_rate),
        .cfg_cont(cfg_cont), .cfg_abs(cfg_abs), .cfg_irq_en(cfg_irq_en),
        .cfg_conv_ch(cfg_conv_ch), .cfg_ref_ch(cfg_ref_ch), .cfg_scale(cfg_scale),
        .start(start), .stop(stop), .done_clr(done_clr), .sample_en(sample_en),
        .conv_start(conv_start), .res_valid(res_valid), .res_data(res_data),
        .busy(busy), .result(result), .done(done), .irq(irq), .mux_ch(mux_ch),
        .ref_ch(ref_ch), .ref_en(ref_en), .scale_sel(scale_sel)
    );

    typedef struct packed {
        logic [7:0]  p;
        logic [7:0]  w;
        logic [7:0]  s;
        logic [15:0] r;
        logic        cont;
        logic        absm;
        logic        ien;
        logic [2:0]  ch;
        logic [2:0]  rch;
        logic [2:0]  sc;
        logic [11:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd7,   8'd3, 8'd2, 16'd0, 1'b0, 1'b1, 1'b1, 3'd5, 3'd2, 3'd1, 12'hA5C},
        '{8'd0,   8'd1, 8'd1, 16'd0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd6, 3'd4, 12'h123},
        '{8'd2,   8'd0, 8'd0, 16'd0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd7, 3'd7, 12'hFFF},
        '{8'd255, 8'd1, 8'd1, 16'd0, 1'b0, 1'b1, 1'b1, 3'd7, 3'd1, 3'd0, 12'h001},
        '{8'd7,   8'd2, 8'd2, 16'd6, 1'b1, 1'b1, 1'b1, 3'd1, 3'd3, 3'd2, 12'h3C3},
        '{8'd3,   8'd1, 8'd1, 16'd1, 1'b1, 1'b0, 1'b0, 3'd4, 3'd5, 3'd3, 12'h0F0}
    };

    function automatic int umax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Analog core model: answers a convert request two cycles later.
    initial begin
        forever begin
            @(negedge clk);
            if (model_on && conv_start) begin
                repeat (2) @(negedge clk);
                res_valid = 1'b1;
                res_data  = model_data;
                @(negedge clk);
                res_valid = 1'b0;
            end
        end
    end

    task automatic load_cfg(input vec_t v);
        @(negedge clk);
        cfg_prescale = v.p; cfg_warm = v.w; cfg_samp = v.s; cfg_rate = v.r;
        cfg_cont = v.cont; cfg_abs = v.absm; cfg_irq_en = v.ien;
        cfg_conv_ch = v.ch; cfg_ref_ch = v.rch; cfg_scale = v.sc;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Count cycles while sample_en equals lvl; returns at the first other value.
    task automatic count_while(input logic lvl, output int c);
        c = 0;
        while (sample_en == lvl && c < 20000) begin
            c++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle(output int c);
        c = 0;
        while (busy && c < 20000) begin
            c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int c;
        int unit;
        int rises;
        vec_t d;
        rst_n = 1'b0; cfg_wr = 0; cfg_prescale = 0; cfg_warm = 0; cfg_samp = 0;
        cfg_rate = 0; cfg_cont = 0; cfg_abs = 0; cfg_irq_en = 0; cfg_conv_ch = 0;
        cfg_ref_ch = 0; cfg_scale = 0; start = 0; stop = 0; done_clr = 0;
        res_valid = 0; res_data = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !irq && !sample_en && !conv_start && result == 0,
            "R1 reset", {busy, done, irq, sample_en, conv_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && result == 0, "R1 after release", {busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            model_data = v.data;
            unit = int'(v.p) + 1;
            clear_done();
            chk(done == 0, "R9 clear", done, 0);
            load_cfg(v);
            // R11 selects
            chk(mux_ch == v.ch, "R11 mux_ch", mux_ch, v.ch);
            chk(scale_sel == v.sc, "R11 scale", scale_sel, v.sc);
            chk(ref_en == !v.absm, "R11 ref_en", ref_en, !v.absm);
            chk(ref_ch == (v.absm ? 3'd0 : v.rch), "R11 ref_ch", ref_ch, v.absm ? 0 : v.rch);
            kick();
            count_while(1'b0, c);
            chk(c == unit * umax(v.w, 1), "R2 warm-up length", c, unit * umax(v.w, 1));
            count_while(1'b1, c);
            chk(c == unit * umax(v.s, 1), "R3 sample length", c, unit * umax(v.s, 1));
            chk(conv_start == 1'b1, "R4 convert pulse", conv_start, 1);
            @(negedge clk);
            chk(conv_start == 1'b0, "R4 pulse width", conv_start, 0);
            if (!v.cont) begin
                c = 0;
                while (!done && c < 50) begin c++; @(negedge clk); end
                chk(done == 1'b1, "R5 done", done, 1);
                chk(result == v.data, "R5 result", result, v.data);
                chk(busy == 1'b0, "R6 single idle", busy, 0);
                chk(irq == v.ien, "R10 irq", irq, v.ien);
                rises = 0;
                for (int k = 0; k < 3 * unit + 20; k++) begin
                    @(negedge clk);
                    if (sample_en) rises++;
                end
                chk(rises == 0, "R6 no repeat", rises, 0);
            end else begin
                count_while(1'b0, c);
                count_while(1'b1, c);
                begin
                    int c2;
                    count_while(1'b0, c2);
                    c = c + c2;
                end
                chk(c == unit * umax(v.r, v.s + 1), "R7 repeat period", c, unit * umax(v.r, v.s + 1));
                chk(done && result == v.data, "R5 cont result", result, v.data);
                chk(irq == v.ien, "R10 cont irq", irq, v.ien);
                // R8 stop during sampling: finishes the conversion then idles
                stop = 1'b1; done_clr = 1'b1;
                @(negedge clk);
                stop = 1'b0; done_clr = 1'b0;
                wait_idle(c);
                chk(busy == 1'b0, "R8 stop reaches idle", busy, 0);
                chk(done == 1'b1, "R8 last conversion stored", done, 1);
                rises = 0;
                for (int k = 0; k < 3 * unit * umax(v.r, v.s + 1); k++) begin
                    @(negedge clk);
                    if (sample_en) rises++;
                end
                chk(rises == 0, "R8 no window after stop", rises, 0);
            end
        end

        // R8 stop during warm-up: idle at once, nothing stored
        clear_done();
        d = '{8'd7, 8'd5, 8'd1, 16'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd0, 3'd0, 12'h0};
        load_cfg(d);
        kick();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(busy == 1'b0, "R8 stop in warm-up", busy, 0);
        rises = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (sample_en || done) rises++;
        end
        chk(rises == 0, "R8 warm-up stop stores nothing", rises, 0);

        // R12 configuration write while busy is dropped
        model_data = 12'h2B4;
        d = '{8'd3, 8'd1, 8'd1, 16'd4, 1'b1, 1'b1, 1'b0, 3'd2, 3'd0, 3'd5, 12'h0};
        load_cfg(d);
        kick();
        d = '{8'd0, 8'd1, 8'd1, 16'd1, 1'b0, 1'b0, 1'b1, 3'd6, 3'd3, 3'd1, 12'h0};
        load_cfg(d);
        chk(mux_ch == 3'd2 && ref_en == 1'b0 && scale_sel == 3'd5, "R12 selects kept", mux_ch, 2);
        count_while(1'b0, c);
        count_while(1'b1, c);
        count_while(1'b0, c);
        count_while(1'b1, c);
        begin
            int c2;
            count_while(1'b0, c2);
            c = c + c2;
        end
        chk(c == 16, "R12 timing kept", c, 16);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_idle(c);
        chk(mux_ch == 3'd2 && irq == 1'b0, "R12 dropped write not applied", mux_ch, 2);

        // R5 res_valid while idle is ignored
        @(negedge clk);
        res_valid = 1'b1; res_data = 12'h777;
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
        chk(result == 12'h2B4 && done == 1'b1, "R5 idle strobe ignored", result, 12'h2B4);

        // R9 store and clear on the same edge: store wins
        model_on = 1'b0;
        d = '{8'd0, 8'd1, 8'd1, 16'd0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 3'd0, 12'h0};
        load_cfg(d);
        kick();
        c = 0;
        while (!conv_start && c < 50) begin c++; @(negedge clk); end
        res_valid = 1'b1; res_data = 12'h456; done_clr = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; done_clr = 1'b0;
        chk(done == 1'b1, "R9 store beats clear", done, 1);
        chk(result == 12'h456, "R9 new result", result, 12'h456);
        clear_done();
        chk(done == 1'b0 && irq == 1'b0, "R9 clear alone", done, 0);
        model_on = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule